// File: doc/BRIEF.md
# Packed Single-Precision Horizontal Add/Subtract Unit

This block is a 128-bit SIMD arithmetic unit. It treats each operand as four IEEE-754 single-precision lanes. A two-bit mode input selects how the lanes are paired:

- **Alternating add/subtract:** each lane of A is combined with the same lane of B. Even lanes subtract and odd lanes add.
- **Horizontal add and horizontal subtract:** adjacent elements within one operand are combined. The low half of the result comes from A and the high half comes from B.
- **Plain element-wise add.**

A router in front of four identical adders picks the operand pair for each lane. It also flips the sign of the second input wherever a lane must subtract.

The unit is fully pipelined. It accepts one operation in every cycle in which `inValid` is high. The matching result appears with `outValid` exactly three cycles later. Arithmetic always rounds to nearest-even. Denormal inputs are treated as zero, results too small to be normal become signed zero, and no exception flags are produced.

Top module: `hsimdUnit`

## Requirements
- R1: Lane k of a vector occupies bits 32k+31:32k, so lane 0 is bits 31:0. `outValid` is high in exactly the cycle that comes three rising edges after a cycle in which `inValid` was sampled high, and back-to-back operations are accepted every cycle.
- R2: With mode 2'b00 (alternating), result lanes 0 and 2 are A[k]−B[k], and lanes 1 and 3 are A[k]+B[k].
- R3: With mode 2'b01 (horizontal add), the result lanes are, in order 0 to 3: A0+A1, A2+A3, B0+B1, B2+B3.
- R4: With mode 2'b10 (horizontal subtract), the result lanes are, in order 0 to 3: A0−A1, A2−A3, B0−B1, B2−B3. The lower-indexed element is always the minuend.
- R5: With mode 2'b11, every result lane k is A[k]+B[k].
- R6: Every finite result is rounded to nearest, with ties going to the value whose mantissa LSB is even.
- R7: A finite result whose magnitude rounds past the largest finite value becomes an infinity of the result's sign (0x7F800000 or 0xFF800000).
- R8: An input with a zero exponent field is treated as a zero of its own sign. An exact result smaller in magnitude than 2^-126 becomes a zero of the result's sign. No output lane ever has a zero exponent field with a nonzero fraction.
- R9: Any NaN input, or infinities of opposite effective sign meeting in an add, gives exactly 0x7FC00000 in that lane. An infinity combined with a finite value passes through with its effective sign.
- R10: An exact cancellation of nonzero values gives +0 (0x00000000). Two zeros give −0 only when both effective signs are negative.
- R11: While reset is held, and after reset until the first result arrives, `outValid` is low and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe for the current operands |
| mode | input | 2 | 00 alternating, 01 horizontal add, 10 horizontal subtract, 11 element-wise add |
| srcA | input | 128 | First operand, four single-precision lanes |
| srcB | input | 128 | Second operand, four single-precision lanes |
| outValid | output | 1 | Result strobe, three cycles after `inValid` |
| result | output | 128 | Four single-precision result lanes |

## Verification
The bench targets the places where a lane can get the wrong operands or the wrong sign:
- Swapping the minuend in horizontal subtract flips the sign of every result lane.
- Routing the B pairs into the low half of the vector puts those results in the wrong lanes.
- Using an alternating pattern with the wrong phase turns sums into differences.

The rounding corner cases are exact ties on both sides of an even LSB, a carry out of the mantissa into the exponent, and sums that overflow to infinity. A design that truncates, or always rounds ties upward, produces a result off by one unit in the last place. Near-total cancellation below the normal range should give a signed zero, not a denormal. NaN and infinity cases show whether a NaN payload leaks through or infinity minus infinity yields an infinity. A long run of back-to-back random operations in all modes catches any slip in the three-cycle alignment between `outValid` and the data.

// File: rtl/hsimdPkg.sv
package hsimdPkg;
  localparam int NUM_LANES = 4;
  localparam int WORD_W    = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = WORD_W - EXP_W - 1;
  localparam int MAN_W     = FRAC_W + 1;
  localparam int EXT_W     = MAN_W + 3;
  localparam int VEC_W     = NUM_LANES * WORD_W;
  localparam int STAGES    = 3;
  localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    MODE_ALT  = 2'b00,
    MODE_HADD = 2'b01,
    MODE_HSUB = 2'b10,
    MODE_EADD = 2'b11
  } opMode_t;

  typedef struct packed {
    logic                 pairRoute;
    logic [NUM_LANES-1:0] negY;
    logic [STAGES-1:0]    stageEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/hsimdFpAdd.sv
module hsimdFpAdd
  import hsimdPkg::*;
(
  input  logic [WORD_W-1:0] opX,
  input  logic [WORD_W-1:0] opY,
  output logic [WORD_W-1:0] sum
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic sx, sy, sL, sS;
  logic [EXP_W-1:0] ex, ey, eL, eS, dExp;
  logic [FRAC_W-1:0] fx, fy, fracOut;
  logic [MAN_W-1:0] mL, mS;
  logic [EXT_W-1:0] shS, alS, nrm;
  logic [EXT_W:0] raw;
  logic [4:0] lz;
  logic [MAN_W:0] rnd;
  logic signed [EXP_W+1:0] eN, eR;
  logic xZero, yZero, xInf, yInf, nanCase, swap, stk, up;

  assign {sx, ex, fx} = opX;
  assign {sy, ey, fy} = opY;

  always_comb begin
    xZero   = (ex == '0);
    yZero   = (ey == '0);
    xInf    = (ex == EXP_MAX) && (fx == '0);
    yInf    = (ey == EXP_MAX) && (fy == '0);
    nanCase = ((ex == EXP_MAX) && (fx != '0)) || ((ey == EXP_MAX) && (fy != '0)) ||
              (xInf && yInf && (sx != sy));
    swap = {ey, fy} > {ex, fx};
    {sL, eL, mL} = swap ? {sy, ey, 1'b1, fy} : {sx, ex, 1'b1, fx};
    {sS, eS, mS} = swap ? {sx, ex, 1'b1, fx} : {sy, ey, 1'b1, fy};
    dExp = eL - eS;
    // align the smaller magnitude, collapsing lost bits into a sticky bit
    shS = '0;
    stk = 1'b1;
    if (dExp < EXP_W'(EXT_W)) begin
      shS = {mS, 3'b000} >> dExp;
      stk = |({mS, 3'b000} & ~({EXT_W{1'b1}} << dExp));
    end
    alS = {shS[EXT_W-1:1], shS[0] | stk};
    raw = (sL == sS) ? ({1'b0, mL, 3'b000} + {1'b0, alS})
                     : ({1'b0, mL, 3'b000} - {1'b0, alS});
    lz = '0;
    for (int k = 0; k < EXT_W; k++) if (raw[k]) lz = 5'(EXT_W - 1 - k);
    if (raw[EXT_W]) begin
      nrm = {raw[EXT_W:2], raw[1] | raw[0]};
      eN  = $signed({2'b00, eL}) + 10'sd1;
    end else begin
      nrm = raw[EXT_W-1:0] << lz;
      eN  = $signed({2'b00, eL}) - $signed({5'b00000, lz});
    end
    up  = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
    rnd = {1'b0, nrm[EXT_W-1:3]} + {{MAN_W{1'b0}}, up};
    eR  = rnd[MAN_W] ? eN + 10'sd1 : eN;
    fracOut = rnd[MAN_W] ? rnd[FRAC_W:1] : rnd[FRAC_W-1:0];

    if (nanCase)              sum = QNAN_WORD;
    else if (xInf)            sum = {sx, EXP_MAX, {FRAC_W{1'b0}}};
    else if (yInf)            sum = {sy, EXP_MAX, {FRAC_W{1'b0}}};
    else if (xZero && yZero)  sum = {sx & sy, {(WORD_W-1){1'b0}}};
    else if (xZero)           sum = opY;
    else if (yZero)           sum = opX;
    else if (raw == '0)       sum = '0;
    else if (eN < 10'sd1)     sum = {sL, {(WORD_W-1){1'b0}}};
    else if (eR > 10'sd254)   sum = {sL, EXP_MAX, {FRAC_W{1'b0}}};
    else                      sum = {sL, eR[EXP_W-1:0], fracOut};
  end
endmodule

// File: rtl/hsimdCtrl.sv
module hsimdCtrl
  import hsimdPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   mode,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  logic [STAGES-1:0] validPipe;
  opMode_t opMode;

  assign opMode = opMode_t'(mode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  assign outValid = validPipe[STAGES-1];

  always_comb begin
    strobes.stageEn = {validPipe[STAGES-2:0], inValid};
    strobes.pairRoute = (opMode == MODE_HADD) || (opMode == MODE_HSUB);
    strobes.negY = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (opMode == MODE_HSUB) strobes.negY[i] = 1'b1;
      if (opMode == MODE_ALT && (i % 2) == 0) strobes.negY[i] = 1'b1;
    end
  end

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));
  assert_hsub_all_neg_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pairRoute && strobes.negY != '0) |-> (&strobes.negY));
  assert_alt_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.pairRoute && strobes.negY != '0) |-> (strobes.negY[0] && !strobes.negY[1]));
  assert_pair_no_mix_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pairRoute |-> ($countones(strobes.negY) == 0 || $countones(strobes.negY) == NUM_LANES));
endmodule

// File: rtl/hsimdDatapath.sv
module hsimdDatapath
  import hsimdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic             outValid,
  output logic [VEC_W-1:0] result
);
  localparam int HALF = NUM_LANES / 2;

  logic [VEC_W-1:0] s1X, s1Y, sumVec, s2Sum;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int PBASE = 2 * (i % HALF);
    logic [WORD_W-1:0] pairLo, pairHi, selX, selY;

    assign pairLo = (i < HALF) ? srcA[PBASE*WORD_W +: WORD_W] : srcB[PBASE*WORD_W +: WORD_W];
    assign pairHi = (i < HALF) ? srcA[(PBASE+1)*WORD_W +: WORD_W] : srcB[(PBASE+1)*WORD_W +: WORD_W];
    assign selX = strobes.pairRoute ? pairLo : srcA[i*WORD_W +: WORD_W];
    assign selY = (strobes.pairRoute ? pairHi : srcB[i*WORD_W +: WORD_W]) ^
                  {strobes.negY[i], {(WORD_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1X[i*WORD_W +: WORD_W] <= '0;
        s1Y[i*WORD_W +: WORD_W] <= '0;
      end else if (strobes.stageEn[0]) begin
        s1X[i*WORD_W +: WORD_W] <= selX;
        s1Y[i*WORD_W +: WORD_W] <= selY;
      end
    end

    hsimdFpAdd u_add (
      .opX(s1X[i*WORD_W +: WORD_W]),
      .opY(s1Y[i*WORD_W +: WORD_W]),
      .sum(sumVec[i*WORD_W +: WORD_W])
    );

    assert_no_denormal_R8: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> !(result[i*WORD_W+FRAC_W +: EXP_W] == '0 && result[i*WORD_W +: FRAC_W] != '0));
    assert_quiet_nan_R9: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && (&result[i*WORD_W+FRAC_W +: EXP_W]) && result[i*WORD_W +: FRAC_W] != '0)
        |-> (result[i*WORD_W +: WORD_W] == QNAN_WORD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Sum  <= '0;
      result <= '0;
    end else begin
      if (strobes.stageEn[1]) s2Sum  <= sumVec;
      if (strobes.stageEn[2]) result <= s2Sum;
    end
  end

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result));
endmodule

// File: rtl/hsimdUnit.sv
module hsimdUnit
  import hsimdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  ctrlStrobes_t strobes;

  hsimdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .strobes(strobes), .outValid(outValid)
  );

  hsimdDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk) !rstN |-> (!outValid && result == '0));
endmodule

// File: tb/sim_hsimdUnit.sv
`timescale 1ns/1ps
module sim_hsimdUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [127:0] srcA = '0, srcB = '0;
  logic outValid;
  logic [127:0] result;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;

  typedef struct {
    int due;
    logic [127:0] expVec;
    string tag;
  } pend_t;
  pend_t pendQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsimdUnit u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
                .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result));

  function automatic real toReal(logic [31:0] w);
    logic [63:0] b;
    if (w[30:23] == 8'h00)      b = {w[31], 63'b0};
    else if (w[30:23] == 8'hFF) b = {w[31], 11'h7FF, w[22:0], 29'b0};
    else                        b = {w[31], 11'(w[30:23]) + 11'd896, w[22:0], 29'b0};
    return $bitstoreal(b);
  endfunction

  function automatic logic [31:0] toSingle(real r);
    logic [63:0] b;
    logic [52:0] m;
    logic [24:0] mm;
    logic up;
    int ee;
    b = $realtobits(r);
    if (b[62:52] == 11'h7FF) return (b[51:0] != 0) ? 32'h7FC00000 : {b[63], 8'hFF, 23'b0};
    if (b[62:52] < 11'd897) return {b[63], 31'b0};
    m  = {1'b1, b[51:0]};
    up = m[28] && ((|m[27:0]) || m[29]);
    mm = {1'b0, m[52:29]} + {24'b0, up};
    ee = int'(b[62:52]) - 896;
    if (mm[24]) begin ee++; mm = mm >> 1; end
    if (ee >= 255) return {b[63], 8'hFF, 23'b0};
    return {b[63], 8'(ee), mm[22:0]};
  endfunction

  function automatic logic [31:0] laneOf(logic [127:0] v, int k);
    return v[k*32 +: 32];
  endfunction

  function automatic logic [31:0] opRef(logic [31:0] x, logic [31:0] y, bit sub);
    return sub ? toSingle(toReal(x) - toReal(y)) : toSingle(toReal(x) + toReal(y));
  endfunction

  function automatic logic [127:0] refModel(logic [1:0] md, logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      case (md)
        2'b00: r[k*32 +: 32] = opRef(laneOf(a, k), laneOf(b, k), (k % 2) == 0);
        2'b11: r[k*32 +: 32] = opRef(laneOf(a, k), laneOf(b, k), 1'b0);
        default: begin
          logic [127:0] s;
          s = (k < 2) ? a : b;
          r[k*32 +: 32] = opRef(laneOf(s, 2*(k%2)), laneOf(s, 2*(k%2)+1), md == 2'b10);
        end
      endcase
    end
    return r;
  endfunction

  task automatic checkOut();
    if (pendQ.size() > 0 && pendQ[0].due == cyc) begin
      pend_t e;
      bit bad;
      e = pendQ.pop_front();
      nChk++;
      bad = 0;
      if (!outValid) begin
        bad = 1;
        $display("FAIL R1 (%s): outValid actual=0 expected=1 at cycle %0d", e.tag, cyc);
      end else begin
        for (int k = 0; k < 4; k++)
          if (laneOf(result, k) !== laneOf(e.expVec, k)) begin
            bad = 1;
            $display("FAIL %s lane %0d: actual=%08h expected=%08h", e.tag, k,
                     laneOf(result, k), laneOf(e.expVec, k));
          end
      end
      if (bad) nFail++;
    end else begin
      nChk++;
      if (outValid !== 1'b0) begin
        nFail++;
        $display("FAIL R1: outValid actual=%0b expected=0 at cycle %0d", outValid, cyc);
      end
    end
  endtask

  task automatic issue(logic [1:0] md, logic [127:0] a, logic [127:0] b, string tag);
    pend_t e;
    @(negedge clk);
    checkOut();
    inValid = 1'b1; mode = md; srcA = a; srcB = b;
    e.due = cyc + 3;
    e.expVec = refModel(md, a, b);
    e.tag = tag;
    pendQ.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkOut();
      inValid = 1'b0;
      srcA = {4{32'hDEAD_BEEF}};
    end
  endtask

  function automatic logic [31:0] randF();
    logic [7:0] e;
    int sel;
    sel = $urandom % 20;
    if (sel == 0)      e = 8'h00;
    else if (sel == 1) e = 8'hFF;
    else if (sel == 2) e = 8'hFE - 8'($urandom % 3);
    else if (sel == 3) e = 8'h01 + 8'($urandom % 3);
    else               e = 8'd120 + 8'($urandom % 16);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  function automatic logic [127:0] randV();
    return {randF(), randF(), randF(), randF()};
  endfunction

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nChk++;
    if (outValid !== 1'b0 || result !== '0) begin
      nFail++;
      $display("FAIL R11: in reset outValid=%0b result=%032h expected 0/0", outValid, result);
    end
    rstN = 1'b1;
    @(negedge clk);
    nChk++;
    if (outValid !== 1'b0 || result !== '0) begin
      nFail++;
      $display("FAIL R11: after reset outValid=%0b result=%032h expected 0/0", outValid, result);
    end

    // main modes with small exact values: lane0=1, lane1=2, lane2=4, lane3=8 in A; B = 0.5,3,0.25,16
    issue(2'b00, {32'h41000000, 32'h40800000, 32'h40000000, 32'h3F800000},
                 {32'h41800000, 32'h3E800000, 32'h40400000, 32'h3F000000}, "R2");
    issue(2'b01, {32'h41000000, 32'h40800000, 32'h40000000, 32'h3F800000},
                 {32'h41800000, 32'h3E800000, 32'h40400000, 32'h3F000000}, "R3");
    issue(2'b10, {32'h41000000, 32'h40800000, 32'h40000000, 32'h3F800000},
                 {32'h41800000, 32'h3E800000, 32'h40400000, 32'h3F000000}, "R4");
    issue(2'b11, {32'h41000000, 32'h40800000, 32'h40000000, 32'h3F800000},
                 {32'h41800000, 32'h3E800000, 32'h40400000, 32'h3F000000}, "R5");
    idle(4);
    // R6: ties to even, both directions; carry into exponent
    issue(2'b11, {32'h3FFFFFFF, 32'h3F800001, 32'h3F800000, 32'h3F800001},
                 {32'h33800000, 32'h33800000, 32'h33800000, 32'h33000000}, "R6");
    // R7: overflow to signed infinity
    issue(2'b01, {32'hFF7FFFFF, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF},
                 {32'h7F000000, 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF}, "R7");
    // R8: underflow to signed zero and denormal inputs flushed
    issue(2'b10, {32'h80800000, 32'h80C00000, 32'h00800000, 32'h00C00000},
                 {32'h80000001, 32'h3F800000, 32'h00400000, 32'h80012345}, "R8");
    // R9: NaN input, inf-inf, inf with finite
    issue(2'b00, {32'h3F800000, 32'h7F800000, 32'h7F800000, 32'h7FA00001},
                 {32'hFF800000, 32'h3F800000, 32'h7F800000, 32'h3F800000}, "R9");
    // R10: exact cancellation and signed zeros
    issue(2'b11, {32'h80000000, 32'h80000000, 32'h00000000, 32'h3FC00000},
                 {32'h00000000, 32'h80000000, 32'h80000000, 32'hBFC00000}, "R10");
    issue(2'b10, {32'h12345678, 32'h12345678, 32'hC0490FDB, 32'hC0490FDB},
                 {32'h00000000, 32'h00000000, 32'h80000000, 32'h80000000}, "R10");
    idle(5);

    // back-to-back random traffic across all modes, with gaps (R1)
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] md;
      logic [127:0] a, b;
      md = 2'($urandom);
      a = randV();
      b = ($urandom % 4 == 0) ? (a ^ 128'($urandom % 8)) : randV();
      if ($urandom % 5 == 0) a = {a[95:64] ^ 32'h1, a[95:64], a[31:0] ^ 32'h3, a[31:0]};
      case (md)
        2'b00: issue(md, a, b, "R2");
        2'b01: issue(md, a, b, "R3");
        2'b10: issue(md, a, b, "R4");
        default: issue(md, a, b, "R5");
      endcase
      if ($urandom % 7 == 0) idle(1 + $urandom % 3);
    end
    idle(6);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule